// File: doc/BRIEF.md
# Delta-modulation output unit

This unit turns a serial stream of 1-bit delta codes into a 7-bit audio level. A down-counting rate timer, whose period comes from a fixed 16-entry table, produces one tick every few hundred clock cycles. On each tick that is not silenced, the unit reads the lowest bit of an 8-bit shift register and moves the level up or down by two. The level saturates so that it always stays inside 0..127. The shift register then moves right by one place.

Every eighth tick marks a byte boundary. At that point the unit takes the next byte from a one-byte sample buffer owned by a fetch unit, using a full flag and a single-cycle take strobe. If no byte is waiting, the unit goes silent, and the level holds until a later boundary finds data. A register port selects the rate index and can load the level directly.

Top module: `delta_level_unit`

## Requirements
- R1: After reset the level is 0, the take strobe is low, the rate index is 0, and the first tick occurs in the 428th clock cycle after reset is released.
- R2: Rate index i (4 bits) gives a tick once every P[i] clock cycles, where P = 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54 for i = 0..15. The tick is high for exactly one cycle.
- R3: On a non-silent tick, shift-register bit 0 = 1 raises the level by 2 if the level is at most 125, and bit 0 = 0 lowers it by 2 if the level is at least 2. Otherwise the level is unchanged. The level changes only on ticks or on a direct load.
- R4: After each non-silent tick the shift register shifts right by one, so the bits of a byte are played least-significant first.
- R5: A byte boundary occurs on every 8th tick. The first tick after reset is a boundary.
- R6: At a boundary with the buffer full, the buffered byte enters the shift register and silence ends. The take strobe is high for that single cycle only, and it coincides with the tick.
- R7: At a boundary with the buffer empty, the unit becomes silent and the take strobe stays low. While the unit is silent, ticks leave the level unchanged.
- R8: A level write sets the level to bits 6:0 of the written data on the next clock. It takes priority over a tick in the same cycle.
- R9: A rate write takes effect at the next timer reload. The countdown already in progress completes with the old period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_we | input | 1 | Write strobe for the rate index |
| rate_idx | input | 4 | New rate index |
| level_we | input | 1 | Write strobe for a direct level load |
| level_data | input | 8 | Load value; bits 6:0 are used |
| buf_full | input | 1 | Sample buffer holds a byte |
| buf_byte | input | 8 | Buffered sample byte |
| buf_take | output | 1 | One-cycle strobe: buffered byte consumed |
| tick | output | 1 | Rate timer tick |
| level | output | 7 | Current output level |

## Verification
`tick` and `buf_take` are combinational from the registered state and the current buffer inputs. The bench compares both in the same cycle as the stimulus, one time unit after the inputs settle. The level, the shift register, the bit count and the silence flag each sit behind one register. The expected level for a tick or a load is therefore compared at the falling edge that follows the rising edge where the tick or load applies. The reference model advances its state at that same rising edge, so every comparison lines up with exactly one clock of latency on the level and none on the strobes.

// File: rtl/delta_level_unit.sv
module delta_level_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rate_we,
  input  logic [3:0] rate_idx,
  input  logic       level_we,
  input  logic [7:0] level_data,
  input  logic       buf_full,
  input  logic [7:0] buf_byte,
  output logic       buf_take,
  output logic       tick,
  output logic [6:0] level
);

  logic [3:0] rate_q;
  logic [8:0] timer_q;
  logic [7:0] shreg_q;
  logic [3:0] bits_q;
  logic       silent_q;
  logic [6:0] level_q;
  logic       boundary;

  function automatic logic [8:0] reload_of(input logic [3:0] i);
    case (i)
      4'd0:  reload_of = 9'd427;
      4'd1:  reload_of = 9'd379;
      4'd2:  reload_of = 9'd339;
      4'd3:  reload_of = 9'd319;
      4'd4:  reload_of = 9'd285;
      4'd5:  reload_of = 9'd253;
      4'd6:  reload_of = 9'd225;
      4'd7:  reload_of = 9'd213;
      4'd8:  reload_of = 9'd189;
      4'd9:  reload_of = 9'd159;
      4'd10: reload_of = 9'd141;
      4'd11: reload_of = 9'd127;
      4'd12: reload_of = 9'd105;
      4'd13: reload_of = 9'd83;
      4'd14: reload_of = 9'd71;
      default: reload_of = 9'd53;
    endcase
  endfunction

  assign tick     = (timer_q == 9'd0);
  assign boundary = (bits_q <= 4'd1);
  assign buf_take = tick & boundary & buf_full;
  assign level    = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q  <= 4'd0;
      timer_q <= reload_of(4'd0);
    end else begin
      if (rate_we) rate_q <= rate_idx;
      timer_q <= tick ? reload_of(rate_q) : timer_q - 9'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q  <= 8'd0;
      bits_q   <= 4'd0;
      silent_q <= 1'b1;
    end else if (tick) begin
      if (boundary) begin
        bits_q   <= 4'd8;
        silent_q <= ~buf_full;
      end else begin
        bits_q <= bits_q - 4'd1;
      end
      if (buf_take) shreg_q <= buf_byte;
      else if (!silent_q) shreg_q <= {1'b0, shreg_q[7:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= 7'd0;
    end else if (level_we) begin
      level_q <= level_data[6:0];
    end else if (tick && !silent_q) begin
      if (shreg_q[0] && level_q <= 7'd125) level_q <= level_q + 7'd2;
      else if (!shreg_q[0] && level_q >= 7'd2) level_q <= level_q - 7'd2;
    end
  end

endmodule

module delta_level_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       buf_take,
  input logic       level_we,
  input logic [7:0] level_data,
  input logic [6:0] level,
  input logic       silent
);

  p_take_with_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_take |-> tick);

  p_take_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_take |=> !buf_take);

  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !level_we) |=> $stable(level));

  p_silent_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && silent && !level_we) |=> $stable(level));

  p_step_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !level_we) |=> (level == $past(level) ||
                             level == $past(level) + 7'd2 ||
                             level == $past(level) - 7'd2));

  p_direct_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    level_we |=> level == $past(level_data[6:0]));

endmodule

bind delta_level_unit delta_level_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .buf_take(buf_take),
  .level_we(level_we), .level_data(level_data), .level(level),
  .silent(silent_q)
);

// File: tb/delta_level_unit_bench.sv
module delta_level_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_we = 1'b0;
  logic [3:0] rate_idx = 4'd0;
  logic       level_we = 1'b0;
  logic [7:0] level_data = 8'd0;
  logic       buf_full = 1'b0;
  logic [7:0] buf_byte = 8'd0;
  logic       buf_take;
  logic       tick;
  logic [6:0] level;

  always #2 clk = ~clk;

  delta_level_unit u_delta_level_unit (
    .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_idx(rate_idx),
    .level_we(level_we), .level_data(level_data), .buf_full(buf_full),
    .buf_byte(buf_byte), .buf_take(buf_take), .tick(tick), .level(level)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit g_tick;
  int ptab[16] = '{428, 380, 340, 320, 286, 254, 226, 214,
                   190, 160, 142, 128, 106, 84, 72, 54};
  int byteq[$];
  int m_timer, m_idx, m_bits, m_sh, m_lvl;
  bit m_silent;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_timer = 427; m_idx = 0; m_bits = 0; m_sh = 0; m_lvl = 0; m_silent = 1;
  endtask

  task automatic cycle();
    bit et, eb, etake, f;
    int nl;
    f = byteq.size() > 0;
    buf_full = f;
    buf_byte = f ? byteq[0][7:0] : 8'd0;
    #1;
    et = (m_timer == 0);
    eb = (m_bits <= 1);
    etake = et && eb && f;
    g_tick = tick;
    check(tick == et, "R2 tick", tick, et);
    check(buf_take == etake, "R6 R7 take", buf_take, etake);
    @(posedge clk);
    nl = m_lvl;
    if (et && !m_silent) begin
      if ((m_sh & 1) && m_lvl <= 125) nl = m_lvl + 2;
      else if (!(m_sh & 1) && m_lvl >= 2) nl = m_lvl - 2;
    end
    if (level_we) nl = level_data & 127;
    if (et) begin
      if (eb) begin
        m_bits = 8;
        if (f) begin m_sh = byteq.pop_front(); m_silent = 0; end
        else begin
          if (!m_silent) m_sh = m_sh >> 1;
          m_silent = 1;
        end
      end else begin
        m_bits = m_bits - 1;
        if (!m_silent) m_sh = m_sh >> 1;
      end
      m_timer = ptab[m_idx] - 1;
    end else m_timer = m_timer - 1;
    if (rate_we) m_idx = rate_idx;
    m_lvl = nl;
    @(negedge clk);
    rate_we = 0;
    level_we = 0;
    check(level == m_lvl[6:0], "R3 R4 R5 R8 level", level, m_lvl);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic load_level(input int v);
    level_we = 1; level_data = v[7:0];
    cycle();
  endtask

  initial begin
    int cnt, gap;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(level == 0, "R1 reset level", level, 0);
    check(buf_take == 0, "R1 reset take", buf_take, 0);
    cnt = 0;
    g_tick = 0;
    while (!g_tick && cnt < 1000) begin
      cnt++;
      if (cnt == 100) begin rate_we = 1; rate_idx = 4'd15; end
      cycle();
    end
    check(cnt == 428, "R1 R9 first tick cycle", cnt, 428);
    gap = 0; g_tick = 0;
    while (!g_tick && gap < 1000) begin gap++; cycle(); end
    check(gap == 54, "R2 period idx15", gap, 54);
    check(level == 0, "R7 silent after empty boundary", level, 0);

    load_level(121);
    byteq.push_back(8'hFF);
    run(2000);
    check(level == 127, "R3 saturate high", level, 127);

    load_level(60);
    byteq.push_back(8'h03);
    run(2000);
    check(level == 52, "R4 lsb first", level, 52);

    load_level(3);
    byteq.push_back(8'h00);
    byteq.push_back(8'h00);
    run(2000);
    check(level == 1, "R3 floor", level, 1);

    load_level(8'hFF);
    check(level == 127, "R8 low seven bits", level, 127);
    load_level(40);
    byteq.push_back(8'h55);
    byteq.push_back(8'hA6);
    byteq.push_back(8'h3C);
    run(600);
    level_we = 1; level_data = 8'd90;
    run(1200);
    check(level == m_lvl[6:0], "R5 R6 multi byte", level, m_lvl);
    run(500);
    check(byteq.size() == 0, "R6 all bytes taken", byteq.size(), 0);

    rate_we = 1; rate_idx = 4'd9;
    g_tick = 0; cnt = 0;
    while (!g_tick && cnt < 1000) begin cnt++; cycle(); end
    gap = 0; g_tick = 0;
    while (!g_tick && gap < 1000) begin gap++; cycle(); end
    check(gap == 160, "R2 R9 period idx9", gap, 160);
    byteq.push_back(8'hF0);
    run(1500);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule